// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter. It runs a fixed conversion cycle from the converter clock. The cycle has three track periods followed by twelve hold periods, and one result bit is decided in each hold period, from the most significant bit down to the least. The block drives a track/hold line and a 12-bit trial code to an external capacitor DAC. At the clock edge that ends each hold period it samples the one-bit comparator answer. The finished code moves into a held output register, which a host reads through two groups of three-state outputs with separate enables.

An active-low start input selects the mode. While start stays low, cycles repeat back to back. If start is high at the edge that ends the first period, the sequencer parks in track mode and keeps the ready flag. When start later goes low, it re-enters the cycle at the last track period. The code is straight binary, with 0 at the low reference and 4095 at the top of the range.

Top module: `sar_conv_sequencer`

## Requirements
- R1: With start_n held low, the period number advances by one on every rising clock edge from 1 to 15, and period 15 is followed directly by period 1, so a conversion takes exactly 15 clocks.
- R2: track_o is high during periods 1 to 3 and while parked, and low during periods 4 to 15.
- R3: trial_o is all zero during track. During period 4 it equals 12'h800, with only bit 11 set.
- R4: During period n (4 to 15), bit 15-n of trial_o is set and all lower bits are zero. Each higher bit holds the comparator value sampled at the rising edge that ended the period in which that bit was tested.
- R5: At the rising edge that ends period 15, all 12 result bits load the output register together. The register then keeps that value until the next such edge, even if the input changes.
- R6: drdy_o rises at the edge that ends period 15, together with the transfer. In free run it falls at the edge that ends period 1.
- R7: If start_n is high at the edge that ends period 1, the sequencer parks. Track stays high, drdy_o keeps its value and no period advances while start_n stays high.
- R8: At the first rising edge with start_n low while parked, the sequencer enters period 3 and drdy_o goes low.
- R9: start_n has no effect during periods 2 to 15.
- R10: oe_hi_n low drives the held bits 11..4 on dout, and high releases them to high impedance. oe_lo_n does the same for bits 3..0, independently.
- R11: With a comparator that reports 1 when the input code is greater than or equal to the trial code, the transferred result equals the input code, including the end codes 0 and 4095.
- R12: While the synchronous active-high reset is asserted, the sequencer goes to period 1 (track high), drdy_o is low, trial_o is zero and the output register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all sequencing on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low start; sampled only at the end of period 1 or while parked |
| cmp_i | input | 1 | Comparator answer, 1 when the input is at or above the trial level |
| track_o | output | 1 | High while the input is being tracked |
| trial_o | output | 12 | Trial code to the capacitor DAC |
| drdy_o | output | 1 | Data-ready flag |
| oe_hi_n | input | 1 | Active-low output enable for bits 11..4 |
| oe_lo_n | input | 1 | Active-low output enable for bits 3..0 |
| dout | output | 12 | Three-state held conversion result |

## Verification
The bench aims at the codes where a single slip in the bit walk shows. Codes 0 and 4095 show an off-by-one in the bit index as a wrong end code, and 2047 and 2048 separate a design that keeps the MSB decision from one that drops it. Start is pulsed high in the middle of a cycle. A design that samples start anywhere but the end of period 1 would park there or stretch the cycle. The park and resume path is checked for re-entry at period 3 with data-ready falling, since a wrong resume point would show a track phase of the wrong length. The input changes while parked and each output group is disabled in turn, so a register that reloads outside the transfer edge, or enables that are tied together, would show as wrong bus values.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

    // Phase the sequencer is in during the current converter period.
    typedef enum logic [1:0] {
        SEQ_TRACK = 2'd0,
        SEQ_PARK  = 2'd1,
        SEQ_TEST  = 2'd2
    } seq_phase_e;

    // Per-period control strobes from the period timer.
    typedef struct packed {
        logic track;    // input connected to the sampling network
        logic load;     // edge ending the last track period seeds the MSB
        logic test;     // a bit is being decided this period
        logic last;     // the LSB is being decided; result transfers at the edge
        logic rdy_clr;  // the edge ending this period lowers data-ready
    } seq_ctl_t;

    function automatic int unsigned cycle_len(input int unsigned code_w,
                                              input int unsigned track_n);
        return code_w + track_n;
    endfunction

    function automatic int unsigned count_w(input int unsigned top);
        return $clog2(top + 1);
    endfunction

endpackage

// File: rtl/sarseq_timer.sv
module sarseq_timer
    import sarseq_pkg::*;
#(
    parameter int unsigned CODE_W  = 12,
    parameter int unsigned TRACK_N = 3,   // must be at least 2
    localparam int unsigned CYCLE  = cycle_len(CODE_W, TRACK_N),
    localparam int unsigned PER_W  = count_w(CYCLE),
    localparam int unsigned IDX_W  = $clog2(CODE_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    output seq_ctl_t         ctl_o,
    output logic [IDX_W-1:0] bit_idx_o
);

    localparam logic [PER_W-1:0] P_FIRST  = PER_W'(1);
    localparam logic [PER_W-1:0] P_SECOND = PER_W'(2);
    localparam logic [PER_W-1:0] P_RESUME = PER_W'(TRACK_N);
    localparam logic [PER_W-1:0] P_LAST   = PER_W'(CYCLE);

    logic [PER_W-1:0] per_q, per_d;
    logic             park_q, park_d;
    seq_phase_e       phase;

    always_comb begin
        if (park_q)                phase = SEQ_PARK;
        else if (per_q <= P_RESUME) phase = SEQ_TRACK;
        else                       phase = SEQ_TEST;
    end

    always_comb begin
        per_d  = per_q;
        park_d = park_q;
        if (park_q) begin
            if (!start_n) begin
                park_d = 1'b0;
                per_d  = P_RESUME;
            end
        end else if (per_q == P_FIRST) begin
            if (start_n) park_d = 1'b1;
            else         per_d  = P_SECOND;
        end else if (per_q == P_LAST) begin
            per_d = P_FIRST;
        end else begin
            per_d = per_q + P_FIRST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q  <= P_FIRST;
            park_q <= 1'b0;
        end else begin
            per_q  <= per_d;
            park_q <= park_d;
        end
    end

    always_comb begin
        ctl_o.track   = (phase != SEQ_TEST);
        ctl_o.load    = (phase == SEQ_TRACK) && (per_q == P_RESUME);
        ctl_o.test    = (phase == SEQ_TEST);
        ctl_o.last    = (phase == SEQ_TEST) && (per_q == P_LAST);
        ctl_o.rdy_clr = !start_n && (park_q || per_q == P_FIRST);
        bit_idx_o     = (phase == SEQ_TEST) ? IDX_W'(P_LAST - per_q) : '0;
    end

    // R1: periods step by one and wrap from the last to the first
    p_period_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!park_q && per_q != P_FIRST && per_q != P_LAST) |=> (per_q == $past(per_q) + P_FIRST));
    p_period_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (!park_q && per_q == P_LAST) |=> (!park_q && per_q == P_FIRST));
    // R9: no park decision outside the first period
    p_no_mid_park_r9: assert property (@(posedge clk) disable iff (rst)
        (!park_q && per_q != P_FIRST) |=> !park_q);
    // R7: parked with start high stays parked
    p_park_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (park_q && start_n) |=> park_q);
    // R8: leaving park lands on the last track period
    p_resume_r8: assert property (@(posedge clk) disable iff (rst)
        (park_q && !start_n) |=> (!park_q && per_q == P_RESUME));

endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar #(
    parameter int unsigned CODE_W = 12,
    localparam int unsigned IDX_W = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              track_i,
    input  logic              load_i,
    input  logic              test_i,
    input  logic              last_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] trial_o,
    output logic [CODE_W-1:0] result_o
);

    localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] trial_q, trial_d;

    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        localparam logic [IDX_W-1:0] OWN_IDX = IDX_W'(i);
        localparam logic [IDX_W-1:0] UP_IDX  = IDX_W'(i + 1);
        localparam logic             SEED    = (i == CODE_W - 1);
        logic under_test, next_down;
        assign under_test = test_i && (bit_idx_i == OWN_IDX);
        assign next_down  = test_i && !last_i && (bit_idx_i == UP_IDX);
        assign trial_d[i] = load_i     ? SEED  :
                            last_i     ? 1'b0  :
                            under_test ? cmp_i :
                            next_down  ? 1'b1  : trial_q[i];
        assign result_o[i] = under_test ? cmp_i : trial_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) trial_q <= '0;
        else     trial_q <= trial_d;
    end

    assign trial_o = trial_q;

    logic [CODE_W-1:0] low_mask;
    assign low_mask = (CODE_W'(1) << bit_idx_i) - CODE_W'(1);

    // R3: first hold period presents only the MSB; track keeps the code clear
    p_msb_first_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(load_i) && !$past(rst)) |-> (trial_q == MSB_ONLY));
    p_track_clear_r3: assert property (@(posedge clk) disable iff (rst)
        track_i |-> (trial_q == '0));
    // R4: bit under test is set and everything below it is clear
    p_trial_shape_r4: assert property (@(posedge clk) disable iff (rst)
        test_i |-> (trial_q[bit_idx_i] && ((trial_q & low_mask) == '0)));
    // R4: a decided bit equals the comparator answer at its closing edge
    p_decision_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(test_i) && !$past(last_i) && !$past(rst)) |-> (trial_q[$past(bit_idx_i)] == $past(cmp_i)));

endmodule

// File: rtl/sarseq_outreg.sv
module sarseq_outreg #(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_i,
    input  logic              rdy_clr_i,
    input  logic [CODE_W-1:0] result_i,
    output logic [CODE_W-1:0] data_o,
    output logic              rdy_o
);

    logic [CODE_W-1:0] data_q;
    logic              rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
        end else begin
            if (xfer_i) data_q <= result_i;
            if (xfer_i)         rdy_q <= 1'b1;
            else if (rdy_clr_i) rdy_q <= 1'b0;
        end
    end

    assign data_o = data_q;
    assign rdy_o  = rdy_q;

    // R5: held result changes only at a transfer edge
    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(xfer_i)) |-> $stable(data_q));
    // R6: ready rises only with a transfer and falls only on a clear request
    p_rdy_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_q) |-> $past(xfer_i));
    p_rdy_fall_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(rdy_q) && !$past(rst)) |-> $past(rdy_clr_i));

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
    import sarseq_pkg::*;
#(
    parameter int unsigned CODE_W  = 12,
    parameter int unsigned TRACK_N = 3,
    parameter int unsigned LO_W    = 4,
    localparam int unsigned IDX_W  = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_n,
    input  logic              cmp_i,
    output logic              track_o,
    output logic [CODE_W-1:0] trial_o,
    output logic              drdy_o,
    input  logic              oe_hi_n,
    input  logic              oe_lo_n,
    output wire  [CODE_W-1:0] dout
);

    seq_ctl_t          ctl;
    logic [IDX_W-1:0]  bit_idx;
    logic [CODE_W-1:0] result;
    logic [CODE_W-1:0] held;

    sarseq_timer #(
        .CODE_W  (CODE_W),
        .TRACK_N (TRACK_N)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_n   (start_n),
        .ctl_o     (ctl),
        .bit_idx_o (bit_idx)
    );

    sarseq_sar #(
        .CODE_W (CODE_W)
    ) u_sar (
        .clk       (clk),
        .rst       (rst),
        .track_i   (ctl.track),
        .load_i    (ctl.load),
        .test_i    (ctl.test),
        .last_i    (ctl.last),
        .bit_idx_i (bit_idx),
        .cmp_i     (cmp_i),
        .trial_o   (trial_o),
        .result_o  (result)
    );

    sarseq_outreg #(
        .CODE_W (CODE_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .xfer_i    (ctl.last),
        .rdy_clr_i (ctl.rdy_clr),
        .result_i  (result),
        .data_o    (held),
        .rdy_o     (drdy_o)
    );

    assign track_o = ctl.track;

    // R10: each output bit is driven by the enable of its group
    for (genvar i = 0; i < CODE_W; i++) begin : g_drv
        logic drive;
        if (i < LO_W) begin : g_lo
            assign drive = !oe_lo_n;
        end else begin : g_hi
            assign drive = !oe_hi_n;
        end
        assign dout[i] = drive ? held[i] : 1'bz;
    end

endmodule

// File: tb/sar_conv_sequencer_tb.sv
module sar_conv_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_n = 1'b0;
    logic        oe_hi_n = 1'b0;
    logic        oe_lo_n = 1'b0;
    logic        cmp;
    logic        track;
    logic [11:0] trial;
    logic        rdy;
    wire  [11:0] dbus;

    int unsigned vin = 0;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // behavioural reference state
    int          m_per = 1;
    bit          m_park = 1'b0;
    bit          m_rdy = 1'b0;
    int unsigned m_data = 0;

    always #2 clk = ~clk;

    // ideal comparator standing in for the analog network (R11)
    assign cmp = (vin >= 32'(trial));

    for (genvar i = 0; i < 12; i++) begin : g_pu
        pullup (dbus[i]);
    end

    sar_conv_sequencer u_dut (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .cmp_i   (cmp),
        .track_o (track),
        .trial_o (trial),
        .drdy_o  (rdy),
        .oe_hi_n (oe_hi_n),
        .oe_lo_n (oe_lo_n),
        .dout    (dbus)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_per = 1; m_park = 1'b0; m_rdy = 1'b0; m_data = 0;
        end else if (m_park) begin
            if (!start_n) begin m_park = 1'b0; m_per = 3; m_rdy = 1'b0; end
        end else if (m_per == 1) begin
            if (start_n) m_park = 1'b1;
            else begin m_per = 2; m_rdy = 1'b0; end
        end else if (m_per == 15) begin
            m_per = 1; m_rdy = 1'b1; m_data = vin;
        end else begin
            m_per++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles, expected fewer than 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int unsigned exp_trial();
        int b;
        if (m_park || m_per <= 3) return 0;
        b = 15 - m_per;
        return ((vin >> (b + 1)) << (b + 1)) | (32'd1 << b);
    endfunction

    function automatic int unsigned exp_bus();
        int unsigned hi, lo;
        hi = oe_hi_n ? 32'hFF0 : (m_data & 32'hFF0);
        lo = oe_lo_n ? 32'h00F : (m_data & 32'h00F);
        return hi | lo;
    endfunction

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, cyc, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        chk({tag, " R6 drdy"}, 32'(rdy), 32'(m_rdy));
        chk({tag, " R2 track"}, 32'(track), (m_park || m_per <= 3) ? 1 : 0);
        chk({tag, " R4 trial"}, 32'(trial), exp_trial());
        chk({tag, " R10 dout"}, 32'(dbus), exp_bus());
    endtask

    int unsigned codes[10] = '{0, 4095, 2048, 2047, 1, 2730, 1365, 165, 3855, 4094};

    initial begin
        // R12: reset state
        repeat (3) tick("R12 reset");
        rst = 1'b0;

        // R1, R11: free run across boundary codes; R9: mid-cycle start pulse
        begin
            int idx = 0;
            while (idx < 10) begin
                tick("R11 free-run");
                if (m_per == 1) begin
                    vin = codes[idx];
                    idx++;
                end
                if (idx == 4 && m_per == 6) start_n = 1'b1;
                if (m_per == 9) start_n = 1'b0;
            end
        end
        repeat (32) tick("R1 cycle");

        // R7: park from period 1, input changes while tracking
        do tick("R7 approach"); while (m_per != 10);
        start_n = 1'b1;
        repeat (20) tick("R7 park");
        vin = 3000;
        repeat (20) tick("R7 park");
        // R8: resume at period 3
        start_n = 1'b0;
        repeat (20) tick("R8 resume");

        // R5, R10: hold a known code while parked and exercise the enables
        do tick("R5 wait"); while (m_per != 1);
        vin = 165;
        do tick("R5 convert"); while (m_per != 2);
        do tick("R5 convert"); while (m_per != 1);
        start_n = 1'b1;
        repeat (3) tick("R5 hold");
        vin = 4000;
        repeat (3) tick("R5 hold");
        oe_hi_n = 1'b1;
        repeat (3) tick("R10 hi off");
        oe_hi_n = 1'b0; oe_lo_n = 1'b1;
        repeat (3) tick("R10 lo off");
        oe_hi_n = 1'b1;
        repeat (3) tick("R10 both off");
        oe_hi_n = 1'b0; oe_lo_n = 1'b0; start_n = 1'b0;
        repeat (40) tick("R11 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule